// File: doc/BRIEF.md
# Integer Add Unit with Carry-Flag Control

This block is the single-cycle add path of a 32-bit load/store processor core. It decodes one instruction word, shows the two source register indices to an external register file, and takes the two operand values back in the same cycle. One clock later it reports the 32-bit sum with a destination-register write strobe. The unit holds the machine-status carry bit. Each result is held valid for one cycle.

Two bits of the major opcode pick one of four add flavours. One bit selects whether the stored carry bit is added in as a carry-in. The other bit selects whether the carry bit is left alone or overwritten with the carry-out. The carry-in select is an opcode bit. It is not the status carry bit, and the two are treated as separate signals throughout. A build-time option makes the all-zero instruction word illegal. In that case the word raises a one-cycle trap pulse and changes no state.

Top module: `add_carry_exec`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rdWrEn`, `carryWrEn` and `illegalTrap` are 0 and `carryFlag` is 0.
- R2: Bit 31 of `instWord` is the most significant bit. The field positions are as follows. The major opcode is `instWord[31:26]` and reads `0,0,0,K,C,0` from bit 31 down to bit 26, with K in bit 28 and C in bit 27. The destination index is `[25:21]`, source A is `[20:16]`, source B is `[15:11]`, and `[10:0]` must be zero. `raAddr` and `rbAddr` show the source fields combinationally.
- R3: A legal add accepted with `instValid=1` produces a result one clock later. In that cycle `rdData` holds the low 32 bits of srcA + srcB + carry-in and `rdAddr` holds the destination index. `rdWrEn` is 1 for that cycle only.
- R4: When C=1 the carry-in is the current `carryFlag`. When C=0 the carry-in is 0, whatever the flag holds.
- R5: When K=0, `carryWrEn` is 1 in the result cycle. `carryFlag` then holds bit 32 of the 33-bit sum srcA + srcB + carry-in.
- R6: When K=1, `carryWrEn` stays 0 and `carryFlag` keeps its value.
- R7: A destination index of 0 gives no `rdWrEn`. The carry flag is still handled as in R5 and R6.
- R8: When `TRAP_ZERO`=1, an accepted all-zero word pulses `illegalTrap` for exactly one cycle. It produces no `rdWrEn` and no `carryWrEn`, and `carryFlag` is left unchanged.
- R9: Nothing is written and `carryFlag` is unchanged in three cases: `instValid=0`, an opcode outside the `000KC0` pattern, or nonzero bits in `[10:0]`.
- R10: Instructions issued on consecutive cycles each use the carry flag as left by the one before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | The instruction word and operands are presented this cycle |
| instWord | input | 32 | Instruction word |
| srcA | input | XLEN | Value of the register selected by `raAddr` |
| srcB | input | XLEN | Value of the register selected by `rbAddr` |
| raAddr | output | 5 | Source A register index |
| rbAddr | output | 5 | Source B register index |
| rdWrEn | output | 1 | Destination write strobe, one cycle |
| rdAddr | output | 5 | Destination register index |
| rdData | output | XLEN | Sum to be written |
| carryWrEn | output | 1 | Carry flag was written this cycle |
| carryFlag | output | 1 | Current status carry bit |
| illegalTrap | output | 1 | Illegal all-zero instruction pulse |

## Verification
The hardest situation to reach is a carry-in select of 1 while the stored flag is set. No input sets the flag directly, so the bench first runs a flag-writing add whose operands overflow, then follows it with a carry-using add. Keep-carry adds are placed after such overflow cases, so a wrongly cleared flag shows up on the next check. The trap case is also issued while the flag is 1, so any accidental execution of the zero word would clear the flag and be visible.

// File: rtl/add_unit_pkg.sv
package add_unit_pkg;
  localparam int INST_W = 32;
  localparam int OPC_W  = 6;
  localparam int REG_AW = 5;

  // Field low-bit positions derived from the fixed instruction layout
  localparam int OPC_LSB = INST_W - OPC_W;
  localparam int RD_LSB  = OPC_LSB - REG_AW;
  localparam int RA_LSB  = RD_LSB - REG_AW;
  localparam int RB_LSB  = RA_LSB - REG_AW;
  localparam int PAD_W   = RB_LSB;

  typedef struct packed {
    logic execute;     // accepted legal add this cycle
    logic useCarryIn;  // opcode carry-in select
    logic keepCarry;   // opcode keep-flag select
    logic writeRd;     // execute with nonzero destination
    logic raiseTrap;   // accepted illegal zero word
  } addStrobes_t;
endpackage

// File: rtl/add_unit_ctrl.sv
module add_unit_ctrl
  import add_unit_pkg::*;
#(
  parameter bit TRAP_ZERO = 1'b1
) (
  input  logic              instValid,
  input  logic [INST_W-1:0] instWord,
  output addStrobes_t       strobes,
  output logic [REG_AW-1:0] rdIdx,
  output logic [REG_AW-1:0] raIdx,
  output logic [REG_AW-1:0] rbIdx
);
  logic [OPC_W-1:0] opcode;
  logic isAddFamily;
  logic padClear;
  logic trapHit;
  logic legal;

  assign opcode = instWord[INST_W-1 -: OPC_W];
  assign rdIdx  = instWord[RD_LSB +: REG_AW];
  assign raIdx  = instWord[RA_LSB +: REG_AW];
  assign rbIdx  = instWord[RB_LSB +: REG_AW];

  // opcode reads 0,0,0,K,C,0 from MSB down
  assign isAddFamily = (opcode[5:3] == 3'b000) && !opcode[0];
  assign padClear    = (instWord[PAD_W-1:0] == '0);

  generate
    if (TRAP_ZERO) begin : g_zeroTrap
      assign trapHit = (instWord == '0);
    end else begin : g_noTrap
      assign trapHit = 1'b0;
    end
  endgenerate

  assign legal = isAddFamily && padClear && !trapHit;

  always_comb begin
    strobes.execute    = instValid && legal;
    strobes.keepCarry  = opcode[2];
    strobes.useCarryIn = opcode[1];
    strobes.writeRd    = instValid && legal && (rdIdx != '0);
    strobes.raiseTrap  = instValid && trapHit;
  end
endmodule

// File: rtl/add_unit_dp.sv
module add_unit_dp
  import add_unit_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  addStrobes_t       strobes,
  input  logic [XLEN-1:0]   srcA,
  input  logic [XLEN-1:0]   srcB,
  input  logic [REG_AW-1:0] rdIdx,
  output logic              rdWrEn,
  output logic [REG_AW-1:0] rdAddr,
  output logic [XLEN-1:0]   rdData,
  output logic              carryWrEn,
  output logic              carryFlag,
  output logic              illegalTrap
);
  localparam int SUM_W = XLEN + 1;

  logic             carryIn;
  logic [SUM_W-1:0] wideSum;
  logic             flagUpdate;

  assign carryIn    = strobes.useCarryIn && carryFlag;
  assign wideSum    = {1'b0, srcA} + {1'b0, srcB} + {{XLEN{1'b0}}, carryIn};
  assign flagUpdate = strobes.execute && !strobes.keepCarry;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdWrEn      <= 1'b0;
      rdAddr      <= '0;
      rdData      <= '0;
      carryWrEn   <= 1'b0;
      carryFlag   <= 1'b0;
      illegalTrap <= 1'b0;
    end else begin
      rdWrEn      <= strobes.writeRd;
      carryWrEn   <= flagUpdate;
      illegalTrap <= strobes.raiseTrap;
      if (strobes.execute) begin
        rdData <= wideSum[XLEN-1:0];
        rdAddr <= rdIdx;
      end
      if (flagUpdate) begin
        carryFlag <= wideSum[XLEN];
      end
    end
  end
endmodule

// File: rtl/add_carry_exec.sv
module add_carry_exec
  import add_unit_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter bit TRAP_ZERO = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instValid,
  input  logic [INST_W-1:0] instWord,
  input  logic [XLEN-1:0]   srcA,
  input  logic [XLEN-1:0]   srcB,
  output logic [REG_AW-1:0] raAddr,
  output logic [REG_AW-1:0] rbAddr,
  output logic              rdWrEn,
  output logic [REG_AW-1:0] rdAddr,
  output logic [XLEN-1:0]   rdData,
  output logic              carryWrEn,
  output logic              carryFlag,
  output logic              illegalTrap
);
  addStrobes_t       strobes;
  logic [REG_AW-1:0] rdIdx;

  add_unit_ctrl #(.TRAP_ZERO(TRAP_ZERO)) u_ctrl (
    .instValid (instValid),
    .instWord  (instWord),
    .strobes   (strobes),
    .rdIdx     (rdIdx),
    .raIdx     (raAddr),
    .rbIdx     (rbAddr)
  );

  add_unit_dp #(.XLEN(XLEN)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .srcA        (srcA),
    .srcB        (srcB),
    .rdIdx       (rdIdx),
    .rdWrEn      (rdWrEn),
    .rdAddr      (rdAddr),
    .rdData      (rdData),
    .carryWrEn   (carryWrEn),
    .carryFlag   (carryFlag),
    .illegalTrap (illegalTrap)
  );
endmodule

// File: rtl/add_carry_exec_chk.sv
module add_carry_exec_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            instValid,
  input logic            kBit,
  input logic            cBit,
  input logic [XLEN-1:0] srcA,
  input logic [XLEN-1:0] srcB,
  input logic            rdWrEn,
  input logic [4:0]      rdAddr,
  input logic [XLEN-1:0] rdData,
  input logic            carryWrEn,
  input logic            carryFlag,
  input logic            illegalTrap
);
  logic [XLEN:0] refSum;
  assign refSum = {1'b0, srcA} + {1'b0, srcB} + {{XLEN{1'b0}}, (cBit && carryFlag)};

  AST_RESULT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    rdWrEn |-> rdData == $past(refSum[XLEN-1:0])); // R3
  AST_WRITE_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (rdWrEn || carryWrEn || illegalTrap) |-> $past(instValid)); // R9
  AST_CARRY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    carryWrEn |-> carryFlag == $past(refSum[XLEN])); // R5
  AST_KEEP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !carryWrEn |-> $stable(carryFlag)); // R6
  AST_KEEP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    carryWrEn |-> !$past(kBit)); // R6
  AST_NO_R0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rdWrEn |-> rdAddr != 5'd0); // R7
  AST_TRAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegalTrap |-> !rdWrEn && !carryWrEn); // R8
  AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    illegalTrap |=> !illegalTrap || $past(instValid)); // R8
endmodule

bind add_carry_exec add_carry_exec_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instValid   (instValid),
  .kBit        (instWord[28]),
  .cBit        (instWord[27]),
  .srcA        (srcA),
  .srcB        (srcB),
  .rdWrEn      (rdWrEn),
  .rdAddr      (rdAddr),
  .rdData      (rdData),
  .carryWrEn   (carryWrEn),
  .carryFlag   (carryFlag),
  .illegalTrap (illegalTrap)
);

// File: tb/add_carry_exec_test.sv
module add_carry_exec_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;

  // entry = {K, C, rd[4:0], a[31:0], b[31:0]}
  localparam logic [70:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 5'd3, 32'h0000_0005, 32'h0000_0007},
    {1'b0, 1'b0, 5'd3, 32'hFFFF_FFFF, 32'h0000_0001},
    {1'b0, 1'b1, 5'd4, 32'h0000_000A, 32'h0000_0014},
    {1'b0, 1'b0, 5'd5, 32'h8000_0000, 32'h8000_0000},
    {1'b1, 1'b0, 5'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {1'b1, 1'b1, 5'd7, 32'h0000_0001, 32'h0000_0002},
    {1'b0, 1'b1, 5'd8, 32'hFFFF_FFFF, 32'h0000_0000},
    {1'b0, 1'b0, 5'd9, 32'h0000_0003, 32'h0000_0004},
    {1'b1, 1'b1, 5'd31, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n;
  logic        instValid;
  logic [31:0] instWord;
  logic [31:0] srcA;
  logic [31:0] srcB;
  logic [4:0]  raAddr;
  logic [4:0]  rbAddr;
  logic        rdWrEn;
  logic [4:0]  rdAddr;
  logic [31:0] rdData;
  logic        carryWrEn;
  logic        carryFlag;
  logic        illegalTrap;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic expFlag = 1'b0;

  add_carry_exec uut (
    .clk(clk), .rst_n(rst_n), .instValid(instValid), .instWord(instWord),
    .srcA(srcA), .srcB(srcB), .raAddr(raAddr), .rbAddr(rbAddr),
    .rdWrEn(rdWrEn), .rdAddr(rdAddr), .rdData(rdData), .carryWrEn(carryWrEn),
    .carryFlag(carryFlag), .illegalTrap(illegalTrap)
  );

  function automatic logic [31:0] mkWord(logic k, logic c, logic [4:0] rd,
                                         logic [4:0] ra, logic [4:0] rb);
    return {3'b000, k, c, 1'b0, rd, ra, rb, 11'd0};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive at negedge, result appears after the next posedge; sample at the following negedge
  task automatic issue(logic [31:0] word, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    instValid = 1'b1; instWord = word; srcA = a; srcB = b;
    @(negedge clk);
    instValid = 1'b0;
  endtask

  task automatic runAdd(string tag, logic k, logic c, logic [4:0] rd,
                        logic [31:0] a, logic [31:0] b);
    logic [32:0] wide;
    wide = {1'b0, a} + {1'b0, b} + {32'd0, (c && expFlag)};
    issue(mkWord(k, c, rd, 5'd10, 5'd21), a, b);
    chk({tag, " R3/R7"}, "rdWrEn", {31'd0, rdWrEn}, {31'd0, (rd != 5'd0)});
    if (rd != 5'd0) begin
      chk({tag, " R3/R4"}, "rdData", rdData, wide[31:0]);
      chk({tag, " R3"}, "rdAddr", {27'd0, rdAddr}, {27'd0, rd});
    end
    chk({tag, " R5/R6"}, "carryWrEn", {31'd0, carryWrEn}, {31'd0, !k});
    if (!k) expFlag = wide[32];
    chk({tag, " R5/R6"}, "carryFlag", {31'd0, carryFlag}, {31'd0, expFlag});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog all actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; instValid = 1'b0; instWord = '0; srcA = '0; srcB = '0;
    repeat (3) @(negedge clk);
    chk("R1", "rdWrEn", {31'd0, rdWrEn}, 32'd0);
    chk("R1", "carryWrEn", {31'd0, carryWrEn}, 32'd0);
    chk("R1", "illegalTrap", {31'd0, illegalTrap}, 32'd0);
    chk("R1", "carryFlag", {31'd0, carryFlag}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "flag after release", {31'd0, carryFlag}, 32'd0);

    // R2: source fields shown combinationally
    instWord = mkWord(1'b0, 1'b0, 5'd1, 5'd17, 5'd30);
    #1;
    chk("R2", "raAddr", {27'd0, raAddr}, 32'd17);
    chk("R2", "rbAddr", {27'd0, rbAddr}, 32'd30);

    // Table walk over the four flavours
    for (int i = 0; i < NVEC; i++) begin
      runAdd($sformatf("vec%0d", i), VEC[i][70], VEC[i][69], VEC[i][68:64],
             VEC[i][63:32], VEC[i][31:0]);
    end

    // R7: destination r0 with overflow still sets the flag
    runAdd("r0dest R7", 1'b0, 1'b0, 5'd0, 32'hFFFF_FFFF, 32'h0000_0001);

    // R8: zero word while flag is 1
    chk("R8", "flag precondition", {31'd0, carryFlag}, 32'd1);
    issue(32'h0, 32'h0, 32'h0);
    chk("R8", "illegalTrap", {31'd0, illegalTrap}, 32'd1);
    chk("R8", "rdWrEn", {31'd0, rdWrEn}, 32'd0);
    chk("R8", "carryWrEn", {31'd0, carryWrEn}, 32'd0);
    chk("R8", "carryFlag", {31'd0, carryFlag}, 32'd1);
    @(negedge clk);
    chk("R8", "trap one cycle", {31'd0, illegalTrap}, 32'd0);

    // R9: foreign opcode, nonzero pad bits, and instValid low
    issue(32'h8000_0000 | mkWord(1'b0, 1'b0, 5'd3, 5'd1, 5'd2), 32'h1, 32'h0);
    chk("R9", "foreign opcode rdWrEn", {31'd0, rdWrEn}, 32'd0);
    chk("R9", "foreign opcode carryWrEn", {31'd0, carryWrEn}, 32'd0);
    issue(mkWord(1'b0, 1'b0, 5'd3, 5'd1, 5'd2) | 32'h1, 32'h1, 32'h0);
    chk("R9", "pad bits rdWrEn", {31'd0, rdWrEn}, 32'd0);
    chk("R9", "pad bits flag", {31'd0, carryFlag}, 32'd1);
    @(negedge clk);
    instValid = 1'b0; instWord = mkWord(1'b0, 1'b0, 5'd3, 5'd1, 5'd2);
    srcA = 32'h1; srcB = 32'h0;
    @(negedge clk);
    chk("R9", "idle rdWrEn", {31'd0, rdWrEn}, 32'd0);
    chk("R9", "idle carryWrEn", {31'd0, carryWrEn}, 32'd0);
    chk("R9", "idle flag", {31'd0, carryFlag}, 32'd1);

    // R10: back-to-back; first clears flag, second uses it with carry-in
    @(negedge clk);
    instValid = 1'b1; instWord = mkWord(1'b0, 1'b0, 5'd2, 5'd1, 5'd1);
    srcA = 32'h1; srcB = 32'h1;
    @(negedge clk);
    chk("R10", "first sum", rdData, 32'h2);
    chk("R10", "first flag", {31'd0, carryFlag}, 32'd0);
    instWord = mkWord(1'b0, 1'b1, 5'd4, 5'd1, 5'd1);
    srcA = 32'hFFFF_FFFF; srcB = 32'h0;
    @(negedge clk);
    instValid = 1'b0;
    chk("R10", "second sum", rdData, 32'hFFFF_FFFF);
    chk("R10", "second flag", {31'd0, carryFlag}, 32'd0);
    chk("R10", "second rdWrEn", {31'd0, rdWrEn}, 32'd1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule